// File: doc/BRIEF.md
# Channel Status Double Buffer

This block collects the channel status bits of an S/PDIF receiver. Each frame of a 192-frame block carries one status bit for channel A and one for channel B. The block takes them from the decoded stream as a strobe, a data bit, a channel indicator and a block-start marker. The bits fill a first-stage capture buffer of 192 bits per channel. When the channel B bit of the last frame arrives, both channels are copied at once into a host-visible buffer of 24 bytes per channel. The host therefore never sees a block that is partly old and partly new.

The host reads the committed bytes through a small register bus at addresses 0x20 to 0x37. A control register selects whether that window shows channel A or channel B, and it also selects the notification mode. A sticky flag, also driven on the `irq` pin, reports a newly committed block. It can fire on every commit, or only when the first five bytes of either channel differ from the block committed before. Reading the flag register clears the flag.

Top module: `cs_dbuf`

## Requirements
- R1: After reset, `irq` is 0, every status byte reads 0, the control register (address 0x10) reads 0 and the flag register (address 0x11) reads 0.
- R2: After a block start, the status bit of frame k for a channel is stored in byte k/8 of that channel, at bit position k%8. Frame 0 goes to bit 0 of byte 0.
- R3: The host-visible bytes change only after the channel B bit of frame 191 arrives, in a block that began with a block-start marker. Until then, reads return the previous block.
- R4: If a block-start marker arrives before frame 191 is complete, the partial block is discarded. The host bytes and the flag are unchanged.
- R5: Status strobes received before any block-start marker has been seen are ignored.
- R6: Control bit 0 selects the view. When it is 0, reads of 0x20+n return byte n of channel A. When it is 1, they return byte n of channel B.
- R7: With control bit 1 cleared, every commit sets the flag.
- R8: With control bit 1 set, a commit sets the flag only when bytes 0 to 4 of channel A or channel B differ from the previously committed block.
- R9: The flag is sticky. It reads as bit 0 of address 0x11 and drives `irq`. A read of 0x11 clears it on the following edge.
- R10: A commit that sets the flag in the same cycle as a clearing read of 0x11 leaves the flag set.
- R11: The control register reads back bits [1:0]. Addresses outside the control register, the flag register and the status window read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_vld | input | 1 | Strobe: one status bit present this cycle |
| cs_bit | input | 1 | Status bit value |
| cs_chan_b | input | 1 | 0 = channel A bit, 1 = channel B bit |
| blk_start | input | 1 | Marks the first bit (channel A, frame 0) of a block |
| reg_addr | input | 7 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rd | input | 1 | Register read strobe (clears the flag when addressing 0x11) |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| irq | output | 1 | Sticky new-status flag |

## Verification
A block commit that sets the flag can land in the same cycle as the host's clearing read of the flag register. The bench provokes this by holding the flag read strobe in the cycle right after the final channel B bit of frame 191 is strobed. It then requires `irq` to stay high, and the new bytes to be visible. A normal read afterwards must return the flag as 1 and then clear it.

// File: rtl/cs_dbuf_pkg.sv
package cs_dbuf_pkg;
    localparam int unsigned CS_FRAMES    = 192;
    localparam int unsigned CS_HDR_BYTES = 5;
    localparam int unsigned CS_ADDR_W    = 7;
    localparam logic [6:0]  CS_WIN_BASE  = 7'h20;
    localparam logic [6:0]  CS_CTRL_ADR  = 7'h10;
    localparam logic [6:0]  CS_FLAG_ADR  = 7'h11;

    typedef struct packed {
        logic view_b;
        logic chg_mode;
        logic flag;
    } cs_regs_t;
endpackage

// File: rtl/cs_dbuf_capture.sv
module cs_dbuf_capture #(
    parameter int unsigned FRAMES = cs_dbuf_pkg::CS_FRAMES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_vld,
    input  logic              cs_bit,
    input  logic              cs_chan_b,
    input  logic              blk_start,
    output logic [FRAMES-1:0] stage_a,
    output logic [FRAMES-1:0] stage_b,
    output logic              commit
);
    localparam int unsigned CNT_W = $clog2(FRAMES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAMES - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              synced;
        logic [FRAMES-1:0] a;
        logic [FRAMES-1:0] b;
        logic              commit;
    } cap_t;

    cap_t cap_d, cap_q;
    logic [CNT_W-1:0] idx;

    always_comb begin
        cap_d        = cap_q;
        cap_d.commit = 1'b0;
        idx          = blk_start ? '0 : cap_q.cnt;
        if (blk_start) begin
            cap_d.synced = 1'b1;
            cap_d.cnt    = '0;
        end
        if (cs_vld && (blk_start || cap_q.synced)) begin
            if (cs_chan_b) begin
                cap_d.b[idx] = cs_bit;
                if (idx == LAST) begin
                    cap_d.commit = 1'b1;
                    cap_d.synced = 1'b0;
                    cap_d.cnt    = '0;
                end else begin
                    cap_d.cnt = idx + 1'b1;
                end
            end else begin
                cap_d.a[idx] = cs_bit;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign stage_a = cap_q.a;
    assign stage_b = cap_q.b;
    assign commit  = cap_q.commit;

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_q.cnt <= LAST); // R2
    AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit); // R3
endmodule

// File: rtl/cs_dbuf_store.sv
module cs_dbuf_store #(
    parameter int unsigned FRAMES    = cs_dbuf_pkg::CS_FRAMES,
    parameter int unsigned HDR_BYTES = cs_dbuf_pkg::CS_HDR_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [FRAMES-1:0] stage_a,
    input  logic [FRAMES-1:0] stage_b,
    output logic [FRAMES-1:0] host_a,
    output logic [FRAMES-1:0] host_b,
    output logic              hdr_changed
);
    localparam int unsigned HDR_BITS = HDR_BYTES * 8;

    typedef struct packed {
        logic [FRAMES-1:0] a;
        logic [FRAMES-1:0] b;
    } host_t;

    host_t host_d, host_q;

    always_comb begin
        host_d = host_q;
        if (commit) begin
            host_d.a = stage_a;
            host_d.b = stage_b;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) host_q <= '0;
        else        host_q <= host_d;
    end

    assign host_a      = host_q.a;
    assign host_b      = host_q.b;
    assign hdr_changed = (stage_a[HDR_BITS-1:0] != host_q.a[HDR_BITS-1:0]) ||
                         (stage_b[HDR_BITS-1:0] != host_q.b[HDR_BITS-1:0]);

    AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(host_a) && $stable(host_b))); // R3
endmodule

// File: rtl/cs_dbuf_regs.sv
module cs_dbuf_regs
    import cs_dbuf_pkg::*;
#(
    parameter int unsigned FRAMES = CS_FRAMES,
    parameter int unsigned ADDR_W = CS_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    input  logic              reg_rd,
    input  logic [FRAMES-1:0] host_a,
    input  logic [FRAMES-1:0] host_b,
    input  logic              commit,
    input  logic              hdr_changed,
    output logic [7:0]        reg_rdata,
    output logic              irq
);
    localparam int unsigned BYTES = FRAMES / 8;
    localparam int unsigned OFF_W = $clog2(BYTES);
    localparam logic [ADDR_W-1:0] BASE  = ADDR_W'(CS_WIN_BASE);
    localparam logic [ADDR_W-1:0] CTRLA = ADDR_W'(CS_CTRL_ADR);
    localparam logic [ADDR_W-1:0] FLAGA = ADDR_W'(CS_FLAG_ADR);

    cs_regs_t regs_d, regs_q;
    logic flag_clr, flag_set, in_win;
    logic [ADDR_W-1:0] rel;
    logic [OFF_W+2:0]  bitpos;

    always_comb begin
        regs_d   = regs_q;
        flag_clr = reg_rd && (reg_addr == FLAGA);
        flag_set = commit && (!regs_q.chg_mode || hdr_changed);
        if (reg_wr && (reg_addr == CTRLA)) begin
            regs_d.view_b   = reg_wdata[0];
            regs_d.chg_mode = reg_wdata[1];
        end
        regs_d.flag = flag_set || (regs_q.flag && !flag_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rel       = reg_addr - BASE;
        in_win    = (reg_addr >= BASE) && (rel < ADDR_W'(BYTES));
        bitpos    = {rel[OFF_W-1:0], 3'b000};
        reg_rdata = '0;
        if (in_win)
            reg_rdata = regs_q.view_b ? host_b[bitpos +: 8] : host_a[bitpos +: 8];
        else if (reg_addr == CTRLA)
            reg_rdata = {6'd0, regs_q.chg_mode, regs_q.view_b};
        else if (reg_addr == FLAGA)
            reg_rdata = {7'd0, regs_q.flag};
    end

    assign irq = regs_q.flag;

    AST_FLAG_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !regs_q.chg_mode) |=> irq); // R7
    AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && commit && regs_q.chg_mode && !hdr_changed) |=> !irq); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(reg_rd && reg_addr == FLAGA)) |=> irq); // R9
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !regs_q.chg_mode && reg_rd && reg_addr == FLAGA) |=> irq); // R10
endmodule

// File: rtl/cs_dbuf.sv
module cs_dbuf
    import cs_dbuf_pkg::*;
#(
    parameter int unsigned FRAMES    = CS_FRAMES,
    parameter int unsigned HDR_BYTES = CS_HDR_BYTES,
    parameter int unsigned ADDR_W    = CS_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_vld,
    input  logic              cs_bit,
    input  logic              cs_chan_b,
    input  logic              blk_start,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    input  logic              reg_rd,
    output logic [7:0]        reg_rdata,
    output logic              irq
);
    logic [FRAMES-1:0] stage_a, stage_b, host_a, host_b;
    logic commit, hdr_changed;

    cs_dbuf_capture #(.FRAMES(FRAMES)) u_cap (
        .clk(clk), .rst_n(rst_n), .cs_vld(cs_vld), .cs_bit(cs_bit),
        .cs_chan_b(cs_chan_b), .blk_start(blk_start),
        .stage_a(stage_a), .stage_b(stage_b), .commit(commit)
    );

    cs_dbuf_store #(.FRAMES(FRAMES), .HDR_BYTES(HDR_BYTES)) u_store (
        .clk(clk), .rst_n(rst_n), .commit(commit),
        .stage_a(stage_a), .stage_b(stage_b),
        .host_a(host_a), .host_b(host_b), .hdr_changed(hdr_changed)
    );

    cs_dbuf_regs #(.FRAMES(FRAMES), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .host_a(host_a), .host_b(host_b),
        .commit(commit), .hdr_changed(hdr_changed),
        .reg_rdata(reg_rdata), .irq(irq)
    );
endmodule

// File: tb/cs_dbuf_tb.sv
module cs_dbuf_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_vld = 1'b0, cs_bit = 1'b0, cs_chan_b = 1'b0, blk_start = 1'b0;
    logic [6:0] reg_addr = '0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic irq;
    int checks = 0;
    int fails = 0;
    logic cur_mode = 1'b0;

    always #4 clk = ~clk;

    cs_dbuf u_dut (
        .clk(clk), .rst_n(rst_n), .cs_vld(cs_vld), .cs_bit(cs_bit),
        .cs_chan_b(cs_chan_b), .blk_start(blk_start), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    typedef struct packed {
        logic [7:0] ha; logic [7:0] ta; logic [7:0] hb; logic [7:0] tb;
        logic mode; logic exp_flag;
    } vec_t;

    localparam vec_t TBL [6] = '{
        '{8'h01, 8'h02, 8'h03, 8'h04, 1'b0, 1'b1},
        '{8'h01, 8'h05, 8'h03, 8'h06, 1'b1, 1'b0},
        '{8'h07, 8'h05, 8'h03, 8'h06, 1'b1, 1'b1},
        '{8'h07, 8'h05, 8'h09, 8'h06, 1'b1, 1'b1},
        '{8'h07, 8'h0B, 8'h09, 8'h06, 1'b1, 1'b0},
        '{8'h07, 8'h0B, 8'h09, 8'h06, 1'b0, 1'b1}
    };

    function automatic logic pbit(input logic [7:0] h, input logic [7:0] t, input int i);
        logic [15:0] s, v;
        s = (i < 40) ? {8'd0, h} : {8'd0, t};
        v = s * 16'(i * 7 + 1) + 16'(i);
        return v[3] ^ v[0] ^ v[6];
    endfunction

    function automatic logic [7:0] exp_byte(input logic [7:0] h, input logic [7:0] t, input int o);
        logic [7:0] r;
        for (int k = 0; k < 8; k++) r[k] = pbit(h, t, o * 8 + k);
        return r;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1 reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [6:0] a, input logic clr, output logic [7:0] v);
        @(negedge clk); reg_addr = a; reg_rd = clr;
        #1 v = reg_rdata;
        @(posedge clk); #1 reg_rd = 1'b0;
    endtask

    task automatic send_one(input logic b, input logic ch, input logic bs);
        @(negedge clk); cs_vld = 1'b1; cs_bit = b; cs_chan_b = ch; blk_start = bs;
        @(negedge clk); cs_vld = 1'b0; blk_start = 1'b0;
    endtask

    task automatic send_blk(input logic [7:0] ha, input logic [7:0] ta, input logic [7:0] hb,
                            input logic [7:0] tb, input int n, input logic with_start);
        for (int j = 0; j < n; j++) begin
            if (j % 2 == 1) send_one(pbit(hb, tb, j / 2), 1'b1, 1'b0);
            else            send_one(pbit(ha, ta, j / 2), 1'b0, with_start && j == 0);
        end
    endtask

    task automatic check_buf(input logic [7:0] ha, input logic [7:0] ta, input logic [7:0] hb,
                             input logic [7:0] tb, input string req);
        logic [7:0] v;
        wr_reg(7'h10, {6'd0, cur_mode, 1'b0});
        for (int o = 0; o < 24; o++) begin
            rd_reg(7'(7'h20 + o), 1'b0, v);
            check({req, " chanA"}, v, exp_byte(ha, ta, o));
        end
        wr_reg(7'h10, {6'd0, cur_mode, 1'b1});
        for (int o = 0; o < 24; o++) begin
            rd_reg(7'(7'h20 + o), 1'b0, v);
            check({req, " R6 chanB"}, v, exp_byte(hb, tb, o));
        end
    endtask

    task automatic check_zero(input string req);
        logic [7:0] v;
        for (int o = 0; o < 24; o++) begin
            rd_reg(7'(7'h20 + o), 1'b0, v);
            check(req, v, 8'h00);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", {7'd0, irq}, 8'h00);
        rd_reg(7'h10, 1'b0, v); check("R1 ctrl", v, 8'h00);
        rd_reg(7'h11, 1'b0, v); check("R1 flag", v, 8'h00);
        check_zero("R1 status");

        // R5 strobes before any block start are ignored
        send_blk(8'h55, 8'h66, 8'h77, 8'h88, 384, 1'b0);
        repeat (3) @(posedge clk); #1;
        check("R5 irq", {7'd0, irq}, 8'h00);
        check_zero("R5 status");

        // table walk: R2, R6, R7, R8
        for (int e = 0; e < 6; e++) begin
            cur_mode = TBL[e].mode;
            wr_reg(7'h10, {6'd0, cur_mode, 1'b0});
            rd_reg(7'h11, 1'b1, v);
            send_blk(TBL[e].ha, TBL[e].ta, TBL[e].hb, TBL[e].tb, 384, 1'b1);
            repeat (3) @(posedge clk); #1;
            check(cur_mode ? "R8 flag" : "R7 flag", {7'd0, irq}, {7'd0, TBL[e].exp_flag});
            check_buf(TBL[e].ha, TBL[e].ta, TBL[e].hb, TBL[e].tb, "R2 bytes");
        end

        // R4 truncated block is discarded
        cur_mode = 1'b0;
        wr_reg(7'h10, 8'h00);
        rd_reg(7'h11, 1'b1, v);
        send_blk(8'h21, 8'h22, 8'h23, 8'h24, 200, 1'b1);
        send_blk(8'h25, 8'h26, 8'h27, 8'h28, 100, 1'b1);
        repeat (3) @(posedge clk); #1;
        check("R4 irq", {7'd0, irq}, 8'h00);
        check_buf(8'h07, 8'h0B, 8'h09, 8'h06, "R4 kept");

        // R3 nothing visible before last B bit
        wr_reg(7'h10, 8'h00);
        send_blk(8'h31, 8'h32, 8'h33, 8'h34, 383, 1'b1);
        repeat (2) @(posedge clk); #1;
        check("R3 irq early", {7'd0, irq}, 8'h00);
        rd_reg(7'h20, 1'b0, v); check("R3 old byte0", v, exp_byte(8'h07, 8'h0B, 0));
        rd_reg(7'h37, 1'b0, v); check("R3 old byte23", v, exp_byte(8'h07, 8'h0B, 23));

        // R10 final strobe, then clearing read during the commit cycle
        send_one(pbit(8'h33, 8'h34, 191), 1'b1, 1'b0);
        reg_addr = 7'h11; reg_rd = 1'b1;
        @(posedge clk); #1 reg_rd = 1'b0;
        @(negedge clk);
        check("R10 set wins", {7'd0, irq}, 8'h01);
        check_buf(8'h31, 8'h32, 8'h33, 8'h34, "R3 new");

        // R9 sticky flag cleared by read
        rd_reg(7'h11, 1'b1, v); check("R9 flag read", v, 8'h01);
        @(negedge clk);
        check("R9 irq cleared", {7'd0, irq}, 8'h00);
        rd_reg(7'h11, 1'b0, v); check("R9 flag reread", v, 8'h00);

        // R11 control readback and unused addresses
        wr_reg(7'h10, 8'hFF);
        rd_reg(7'h10, 1'b0, v); check("R11 ctrl", v, 8'h03);
        rd_reg(7'h00, 1'b0, v); check("R11 addr00", v, 8'h00);
        rd_reg(7'h38, 1'b0, v); check("R11 addr38", v, 8'h00);
        rd_reg(7'h1F, 1'b0, v); check("R11 addr1F", v, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule